// File: doc/BRIEF.md
# Packet FIFO with Threshold-Driven Data-Available

This block is a single-clock packet buffer for the receive side of a streaming link. Each write stores one data word together with a start-of-packet flag and an end-of-packet flag. The consumer reads the stored elements in order. Each read returns its word one cycle after the request, with a valid strobe beside it.

A data-available output tells the consumer when it is worth starting a burst of reads. It rises once the number of stored elements reaches a threshold. A packet-end mode can also raise it when fewer elements are held but at least one of them closes a packet, so that short packets do not sit in the buffer waiting for more data. The threshold and the packet-end mode are captured while reset is high and are held for the whole of operation.

The block protects itself against misuse. A read of an empty buffer does nothing. A write into a full buffer is dropped and flagged on an overflow output. A build parameter chooses how that flag behaves: either it pulses once for each dropped write, or it stays high until the buffer has been drained.

Top module: `pkt_fifo`

## Requirements
- R1: The buffer holds up to DEPTH elements and returns them in write order. `full` is high exactly when DEPTH elements are stored, and a write is accepted whenever the buffer is not full.
- R2: `dav` is high whenever the number of stored elements is greater than or equal to the captured threshold. A captured threshold of 0 keeps `dav` high even when the buffer is empty.
- R3: With packet-end mode captured as 1, `dav` is also high whenever at least one stored element has its end-of-packet flag set, whatever the fill level. With the mode captured as 0, only the threshold drives `dav`.
- R4: `cfg_thresh` and `cfg_eop_mode` are sampled on every clock edge while `rst` is high. Changes to them while `rst` is low have no effect on `dav`.
- R5: `empty` is high exactly when no element is stored. A read request made while the buffer is empty is ignored: `rd_valid` stays low in the next cycle and the contents are unchanged.
- R6: A write made while the buffer is full and no read is accepted in the same cycle is discarded, and `ovf_err` is high in the next cycle.
- R7: A write and a read in the same cycle on a full buffer are both accepted. The level stays at DEPTH, and no overflow is reported for that write.
- R8: With STICKY=0, `ovf_err` is high for exactly one cycle after each discarded write. With STICKY=1, it rises after a discarded write and stays high until the clock edge on which the stored count returns to 0.
- R9: An accepted read presents its element on `rd_data`, `rd_sop` and `rd_eop`, with `rd_valid` high, in the cycle after the request. `rd_valid` is low after any cycle with no accepted read.
- R10: Synchronous active-high reset empties the buffer and clears `rd_valid` and `ovf_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the configuration inputs are captured while it is high |
| cfg_thresh | input | CW = clog2(DEPTH+1) | Fill threshold for `dav`, in elements |
| cfg_eop_mode | input | 1 | 1 enables the packet-end override of `dav` |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Data word to store |
| wr_sop | input | 1 | Start-of-packet flag of the written element |
| wr_eop | input | 1 | End-of-packet flag of the written element |
| full | output | 1 | DEPTH elements are stored |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Data word of the last accepted read |
| rd_sop | output | 1 | Start-of-packet flag of the last accepted read |
| rd_eop | output | 1 | End-of-packet flag of the last accepted read |
| rd_valid | output | 1 | The read outputs hold a new element this cycle |
| empty | output | 1 | No element is stored |
| dav | output | 1 | Data available, from the threshold or the packet-end override |
| ovf_err | output | 1 | A write was dropped because the buffer was full |

## Verification
The bound checker checks these properties on every cycle:
- The stored count never exceeds DEPTH.
- The count of stored packet ends never exceeds the stored count.
- A read of an empty buffer never yields `rd_valid`, and a `rd_valid` always follows an accepted read.
- A write into a full buffer with no read always raises `ovf_err`.
- A write and a read together on a full buffer raise nothing (pulse variant).
- The sticky flag cannot drop while more than one element remains.

Some behaviours can only be shown by the bench's sweeps, which cover every threshold and both packet-end modes. These are:
- the exact level at which `dav` rises and falls;
- the packet-end override;
- that captured configuration is immune to later changes;
- the in-order data.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

    // Packet markers stored beside each data word
    typedef struct packed {
        logic sop;
        logic eop;
    } pf_mark_t;

    // Per-cycle operation, encoded as {write accepted, read accepted}
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } pf_op_e;

    // Width needed to hold the values 0..n
    function automatic int unsigned pf_cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

    // Pointer advance with wrap at the buffer depth
    function automatic int unsigned pf_wrap_inc(input int unsigned p, input int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/pf_ctrl.sv
module pf_ctrl
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_eop,
    input  logic          rd_en,
    input  logic          head_eop,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic          ovf_now,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] level,
    output logic [CW-1:0] level_next,
    output logic [CW-1:0] eop_cnt
);

    logic    is_full;
    logic    is_empty;
    logic    eop_in;
    logic    eop_out;
    pf_op_e  op;

    assign is_full  = (level == CW'(DEPTH));
    assign is_empty = (level == '0);
    assign rd_ok    = rd_en && !is_empty;
    assign wr_ok    = wr_en && (!is_full || rd_ok);
    assign ovf_now  = wr_en && !wr_ok;
    assign op       = pf_op_e'({wr_ok, rd_ok});
    assign eop_in   = wr_ok && wr_eop;
    assign eop_out  = rd_ok && head_eop;

    always_comb begin
        unique case (op)
            OP_PUSH: level_next = level + CW'(1);
            OP_POP:  level_next = level - CW'(1);
            default: level_next = level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            eop_cnt <= '0;
        end else begin
            level <= level_next;
            if (wr_ok) wr_ptr <= AW'(pf_wrap_inc(int'(wr_ptr), DEPTH));
            if (rd_ok) rd_ptr <= AW'(pf_wrap_inc(int'(rd_ptr), DEPTH));
            if (eop_in && !eop_out)      eop_cnt <= eop_cnt + CW'(1);
            else if (!eop_in && eop_out) eop_cnt <= eop_cnt - CW'(1);
        end
    end

endmodule

// File: rtl/pf_storage.sv
module pf_storage
    import pkt_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int EW = DATA_W + $bits(pf_mark_t)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  pf_mark_t          wr_mark,
    input  logic              rd_ok,
    input  logic [AW-1:0]     rd_ptr,
    output pf_mark_t          head_mark,
    output logic [DATA_W-1:0] rd_data,
    output pf_mark_t          rd_mark,
    output logic              rd_valid
);

    logic [EW-1:0] mem [DEPTH];
    logic [EW-1:0] head;

    assign head      = mem[rd_ptr];
    assign head_mark = pf_mark_t'(head[EW-1:DATA_W]);

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= {wr_mark, wr_data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_mark  <= '0;
        end else begin
            rd_valid <= rd_ok;
            if (rd_ok) begin
                rd_data <= head[DATA_W-1:0];
                rd_mark <= head_mark;
            end
        end
    end

endmodule

// File: rtl/pf_dav.sv
module pf_dav #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_thresh,
    input  logic          cfg_eop_mode,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] eop_cnt,
    output logic          dav
);

    logic [CW-1:0] thr_q;
    logic          eop_mode_q;

    // Configuration is captured only while reset is asserted
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q      <= cfg_thresh;
            eop_mode_q <= cfg_eop_mode;
        end
    end

    assign dav = (level >= thr_q) || (eop_mode_q && (eop_cnt != '0));

endmodule

// File: rtl/pf_err.sv
module pf_err #(
    parameter int CW     = 5,
    parameter bit STICKY = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ovf_now,
    input  logic [CW-1:0] level_next,
    output logic          ovf_err
);

    logic err_d;

    generate
        if (STICKY) begin : g_hold
            // Held until the edge on which the buffer becomes empty
            assign err_d = ovf_now || (ovf_err && (level_next != '0));
        end else begin : g_pulse
            assign err_d = ovf_now;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ovf_err <= 1'b0;
        else     ovf_err <= err_d;
    end

endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo
    import pkt_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter bit STICKY = 1'b0,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     cfg_thresh,
    input  logic              cfg_eop_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    output logic              full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic              rd_valid,
    output logic              empty,
    output logic              dav,
    output logic              ovf_err
);

    logic          wr_ok;
    logic          rd_ok;
    logic          ovf_now;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] level_q;
    logic [CW-1:0] level_next;
    logic [CW-1:0] eop_cnt_q;
    pf_mark_t      head_mark;
    pf_mark_t      wr_mark;
    pf_mark_t      rd_mark;

    assign wr_mark = '{sop: wr_sop, eop: wr_eop};

    pf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_eop     (wr_eop),
        .rd_en      (rd_en),
        .head_eop   (head_mark.eop),
        .wr_ok      (wr_ok),
        .rd_ok      (rd_ok),
        .ovf_now    (ovf_now),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .level      (level_q),
        .level_next (level_next),
        .eop_cnt    (eop_cnt_q)
    );

    pf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_ok     (wr_ok),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data),
        .wr_mark   (wr_mark),
        .rd_ok     (rd_ok),
        .rd_ptr    (rd_ptr),
        .head_mark (head_mark),
        .rd_data   (rd_data),
        .rd_mark   (rd_mark),
        .rd_valid  (rd_valid)
    );

    pf_dav #(.CW(CW)) u_dav (
        .clk          (clk),
        .rst          (rst),
        .cfg_thresh   (cfg_thresh),
        .cfg_eop_mode (cfg_eop_mode),
        .level        (level_q),
        .eop_cnt      (eop_cnt_q),
        .dav          (dav)
    );

    pf_err #(.CW(CW), .STICKY(STICKY)) u_err (
        .clk        (clk),
        .rst        (rst),
        .ovf_now    (ovf_now),
        .level_next (level_next),
        .ovf_err    (ovf_err)
    );

    assign full   = (level_q == CW'(DEPTH));
    assign empty  = (level_q == '0);
    assign rd_sop = rd_mark.sop;
    assign rd_eop = rd_mark.eop;

endmodule

// File: rtl/pkt_fifo_chk.sv
module pkt_fifo_chk #(
    parameter int DEPTH  = 16,
    parameter int CW     = 5,
    parameter bit STICKY = 1'b0
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full,
    input logic          empty,
    input logic          rd_valid,
    input logic          ovf_err,
    input logic [CW-1:0] level,
    input logic [CW-1:0] eop_cnt
);

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

    assert_eop_within_level_R3: assert property (@(posedge clk) disable iff (rst)
        eop_cnt <= level);

    assert_empty_read_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> !rd_valid);

    assert_valid_follows_read_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en && !empty));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> ovf_err);

    assert_full_rw_clean_R7: assert property (@(posedge clk) disable iff (rst)
        (!STICKY && wr_en && rd_en && full) |=> !ovf_err);

    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (STICKY && ovf_err && (level > CW'(1))) |=> ovf_err);

    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (!STICKY && ovf_err) |-> $past(wr_en && full && !rd_en));

endmodule

bind pkt_fifo pkt_fifo_chk #(.DEPTH(DEPTH), .CW(CW), .STICKY(STICKY)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .full     (full),
    .empty    (empty),
    .rd_valid (rd_valid),
    .ovf_err  (ovf_err),
    .level    (level_q),
    .eop_cnt  (eop_cnt_q)
);

// File: tb/tb_pkt_fifo.sv
`timescale 1ns/1ps
module tb_pkt_fifo;

    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cfg_thresh = '0;
    logic          cfg_eop_mode = 1'b0;
    logic          wr_en = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;

    logic          full0, empty0, dav0, ovf0, rv0, rs0, re0;
    logic [DW-1:0] rdd0;
    logic          full1, empty1, dav1, ovf1, rv1, rs1, re1;
    logic [DW-1:0] rdd1;

    always #4 clk = ~clk;  // 125 MHz

    pkt_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .STICKY(1'b0)) dut (
        .clk(clk), .rst(rst), .cfg_thresh(cfg_thresh), .cfg_eop_mode(cfg_eop_mode),
        .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop), .full(full0),
        .rd_en(rd_en), .rd_data(rdd0), .rd_sop(rs0), .rd_eop(re0), .rd_valid(rv0),
        .empty(empty0), .dav(dav0), .ovf_err(ovf0));

    pkt_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .STICKY(1'b1)) dut_r (
        .clk(clk), .rst(rst), .cfg_thresh(cfg_thresh), .cfg_eop_mode(cfg_eop_mode),
        .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop), .full(full1),
        .rd_en(rd_en), .rd_data(rdd1), .rd_sop(rs1), .rd_eop(re1), .rd_valid(rv1),
        .empty(empty1), .dav(dav1), .ovf_err(ovf1));

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Reference state: queue entries are {sop, eop, data}
    logic [DW+1:0] q[$];
    int m_thr;
    bit m_eopm;
    bit e_err0, e_err1, e_rv;
    logic [DW+1:0] e_rd;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int eops_stored();
        int n = 0;
        foreach (q[i]) if (q[i][DW]) n++;
        return n;
    endfunction

    task automatic compare_all();
        int  lvl = q.size();
        bit  e_dav = (lvl >= m_thr) || (m_eopm && eops_stored() > 0);
        chk(full0 == (lvl == DEPTH), "R1 full", full0, lvl == DEPTH);
        chk(empty0 == (lvl == 0), "R5 empty", empty0, lvl == 0);
        chk(dav0 == e_dav, "R2 R3 R4 dav", dav0, e_dav);
        chk(dav1 == e_dav, "R2 R3 R4 dav sticky inst", dav1, e_dav);
        chk(rv0 == e_rv && rv1 == e_rv, "R9 R5 rd_valid", rv0, e_rv);
        if (e_rv) begin
            chk({rs0, re0, rdd0} == e_rd, "R1 R9 read element", int'({rs0, re0, rdd0}), int'(e_rd));
            chk({rs1, re1, rdd1} == e_rd, "R1 R9 read element sticky inst", int'({rs1, re1, rdd1}), int'(e_rd));
        end
        chk(ovf0 == e_err0, "R6 R7 R8 ovf_err pulse", ovf0, e_err0);
        chk(ovf1 == e_err1, "R6 R7 R8 ovf_err sticky", ovf1, e_err1);
    endtask

    task automatic step(input bit w, input bit s, input bit e, input logic [DW-1:0] d, input bit r);
        bit rd_ok, wr_ok, ovf;
        @(negedge clk);
        wr_en = w; wr_sop = s; wr_eop = e; wr_data = d; rd_en = r;
        rd_ok = r && (q.size() > 0);
        wr_ok = w && ((q.size() < DEPTH) || rd_ok);
        ovf   = w && !wr_ok;
        e_rv  = rd_ok;
        if (rd_ok) e_rd = q.pop_front();
        if (wr_ok) q.push_back({s, e, d});
        e_err0 = ovf;
        e_err1 = ovf || (e_err1 && q.size() != 0);
        @(posedge clk);
        #2;
        compare_all();
    endtask

    task automatic do_reset(input int thr, input bit em);
        @(negedge clk);
        rst = 1'b1; wr_en = 0; rd_en = 0;
        cfg_thresh = CW'(thr); cfg_eop_mode = em;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        m_thr = thr; m_eopm = em;
        e_err0 = 0; e_err1 = 0; e_rv = 0;
        // R4: disturb the configuration after reset; it must be ignored
        cfg_thresh   = CW'(DEPTH - thr);
        cfg_eop_mode = !em;
        #1;
        // R10 reset state
        chk(empty0 && empty1 && !full0, "R10 empty after reset", empty0, 1);
        chk(!rv0 && !rv1, "R10 rd_valid after reset", rv0, 0);
        chk(!ovf0 && !ovf1, "R10 ovf_err after reset", ovf0, 0);
        chk(dav0 == (thr == 0), "R2 R10 dav after reset", dav0, thr == 0);
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int thr = 0; thr <= DEPTH; thr++) begin
            for (int em = 0; em < 2; em++) begin
                do_reset(thr, em[0]);
                // R5: reads on empty
                step(0, 0, 0, 8'h00, 1);
                // fill past full (R1, R6), packet end on element 2
                for (int i = 0; i < DEPTH + 2; i++)
                    step(1, i == 0, i == 2, DW'(8'h10 + thr * 16 + i), 0);
                // R7: simultaneous read and write on full
                step(1, 1, 1, 8'hA5, 1);
                // drain past empty (R8 sticky release, R5)
                for (int i = 0; i < DEPTH + 2; i++)
                    step(0, 0, 0, 8'h00, 1);
                // mixed traffic
                for (int i = 0; i < 40; i++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    step(lfsr[0] | lfsr[5], lfsr[1], lfsr[2] & lfsr[3], lfsr[15:8], lfsr[4] & lfsr[6]);
                end
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule